// File: doc/BRIEF.md
# Power-Management Companion Register File

This block is the register file of a power-management companion chip. It holds 32 register indices, each 16 bits wide, and sits behind a single-cycle register access port: a command with an index, a direction and write data is presented for one clock. Read data is returned on the next cycle. The register file holds:

- an interrupt status word and an interrupt mask, combined into one registered interrupt line;
- an ADC channel selector, whose readback carries a preset conversion result;
- sticky per-channel sample flags;
- a clock calibration word;
- two control words and a status word;
- a watchdog index that can request system shutdown.

A power-key event input updates the interrupt and status words. No conversion hardware is modelled. The result for each channel comes from a fixed table. The placeholder indices read as zero and ignore writes. An index that does not exist produces a one-cycle error pulse and leaves all state unchanged. A write to a read-only index that does not accept writes is treated the same way.

Top module: `pmic_regfile`

## Requirements
- R1: `irq_o` is high exactly when some bit is 1 in (interrupt status AND NOT interrupt mask). A mask bit of 1 blocks that source. `irq_o` is registered and reflects a write or event one cycle after it is presented.
- R2: After reset the following values hold:
  - interrupt mask = 0xFFFF;
  - interrupt status = 0x0000;
  - status word = 0x0020;
  - calibration word = 0x0001;
  - both control words, the sample flags and the channel = 0;
  - `irq_o`, `shutdown_o`, `acc_err_o` and `acc_rdata_o` = 0.
- R3: A write to index 0x01 XORs the write data into the interrupt status word. Index 0x01 reads back the interrupt status.
- R4: A write to index 0x08 does three things: it loads the channel from write-data bits 13:10, it sets interrupt status bit 8, and it sets the sample-flag bit whose position equals the new channel.
- R5: A read of index 0x08 returns the channel in bits 13:10, the channel's 10-bit preset result in bits 9:0, and zero in bits 15:14. The preset results by channel are:
  - 1 = 0x3C2, 2 = 0x0FC, 3 = 0x165, 4 = 0x07B, 5 = 0x3FF;
  - 6 = 0x011, 7 = 0x011, 8 = 0x250;
  - 10 = 0x002, 11 = 0x011, 12 = 0x3D0, 13 = 0x330;
  - all other channels = 0.
- R6: A write to index 0x09 clears every sample-flag bit that is 1 in the write data. Index 0x09 reads back the sample flags.
- R7: A write of 0x0000 to index 0x17 raises `shutdown_o` on the next cycle only when bit 1 of the control word at index 0x0D is 1. `shutdown_o` then stays high until reset. A nonzero write, or a zero write while that bit is 0, has no effect.
- R8: A read of index 0x00 returns 0x0215 with bit 7 replaced by `variant_i` at the time of the read.
- R9: A cycle with `key_event_i` high sets interrupt status bit 0. It also sets status-word bit 5 (read at index 0x16) to the inverse of `key_pressed_i`. The event is applied after a write to index 0x01 in the same cycle.
- R10: A read of index 0x07 or 0x12–0x15 is an error. A write to any of those indices, or to 0x00, 0x04 or 0x16, is also an error. On an error access:
  - `acc_err_o` pulses for exactly the next cycle;
  - a read returns 0;
  - no register changes.

  `acc_err_o` is low in any cycle that follows a cycle without an access.
- R11: `acc_rdata_o` is loaded in the cycle after every read and holds its value until the next read. Indices 0x02, 0x06, 0x0D and 0x0E read back the last value written to them. Indices 0x03–0x05, 0x0A–0x0C, 0x0F–0x11 and 0x17–0x1F read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_i | input | 1 | Variant strap reflected in ID bit 7 |
| acc_valid_i | input | 1 | Access command valid this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_index_i | input | 5 | Register index |
| acc_wdata_i | input | 16 | Write data |
| key_event_i | input | 1 | One-cycle power-key event strobe |
| key_pressed_i | input | 1 | Key level qualifying the event (1 = pressed) |
| acc_rdata_o | output | 16 | Read data, valid the cycle after a read |
| acc_err_o | output | 1 | Error pulse for an undefined or illegal access |
| irq_o | output | 1 | Registered combined interrupt |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The bench goes after the XOR semantics of the status word:

- Writing a set bit clears it. A design that OR-set or plain-loaded the status word would leave `irq_o` high after a clear.
- A key event in the same cycle as a clearing XOR must still leave bit 0 set. Applying the operations in the other order would drop the event.

It checks the ADC readback for all sixteen channels, including the channels that have no preset result. A wrong table entry or a shifted channel field shows up as a mismatching read word.

Error accesses are aimed at written registers. This exposes a decoder that lets an illegal write, such as a write to the ID or status index, corrupt state.

The watchdog is probed with a nonzero value and with the enable bit clear before the real request. A design that ignored either gate would raise `shutdown_o` early.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

    localparam int unsigned DW    = 16;
    localparam int unsigned IW    = 5;
    localparam int unsigned CHW   = 4;
    localparam int unsigned RESW  = 10;
    localparam int unsigned NCH   = 1 << CHW;
    localparam int unsigned ADC_PAD = DW - CHW - RESW;

    // Register indices whose position matters to software
    localparam logic [IW-1:0] IDX_ID       = 5'h00;
    localparam logic [IW-1:0] IDX_IRQ_ST   = 5'h01;
    localparam logic [IW-1:0] IDX_IRQ_MASK = 5'h02;
    localparam logic [IW-1:0] IDX_CAL      = 5'h06;
    localparam logic [IW-1:0] IDX_ADC      = 5'h08;
    localparam logic [IW-1:0] IDX_SAMPLE   = 5'h09;
    localparam logic [IW-1:0] IDX_CTRL1    = 5'h0D;
    localparam logic [IW-1:0] IDX_CTRL2    = 5'h0E;
    localparam logic [IW-1:0] IDX_STATUS   = 5'h16;
    localparam logic [IW-1:0] IDX_WDOG     = 5'h17;

    // Bit positions
    localparam int unsigned IRQ_KEY_BIT   = 0;
    localparam int unsigned IRQ_ADC_BIT   = 8;
    localparam int unsigned ST_KEYUP_BIT  = 5;
    localparam int unsigned WD_EN_BIT     = 1;
    localparam int unsigned ADC_CH_LSB    = 10;
    localparam int unsigned ID_VAR_BIT    = 7;

    // Reset and constant values
    localparam logic [DW-1:0] ID_BASE    = 16'h0215;
    localparam logic [DW-1:0] RST_MASK   = 16'hFFFF;
    localparam logic [DW-1:0] RST_STATUS = 16'h0020;
    localparam logic [DW-1:0] RST_CAL    = 16'h0001;

    typedef struct packed {
        logic id;
        logic irq_st;
        logic irq_mask;
        logic cal;
        logic adc;
        logic sample;
        logic ctrl1;
        logic ctrl2;
        logic status;
        logic wdog;
    } reg_sel_t;

    typedef struct packed {
        logic [DW-1:0]  irq_st;
        logic [DW-1:0]  irq_mask;
        logic [DW-1:0]  cal;
        logic [NCH-1:0] sample;
        logic [DW-1:0]  ctrl1;
        logic [DW-1:0]  ctrl2;
        logic [DW-1:0]  status;
        logic [CHW-1:0] chan;
        logic [DW-1:0]  rdata;
        logic           err;
        logic           irq;
        logic           shutdown;
    } state_t;

endpackage

// File: rtl/pmic_idx_decode.sv
module pmic_idx_decode
    import pmic_pkg::*;
(
    input  logic [IW-1:0] index_i,
    input  logic          write_i,
    output reg_sel_t      sel_o,
    output logic          legal_o
);

    logic exists;
    logic read_only;

    always_comb begin
        sel_o     = '0;
        exists    = 1'b1;
        read_only = 1'b0;
        case (index_i)
            IDX_ID: begin
                sel_o.id  = 1'b1;
                read_only = 1'b1;
            end
            IDX_IRQ_ST:   sel_o.irq_st   = 1'b1;
            IDX_IRQ_MASK: sel_o.irq_mask = 1'b1;
            5'h04:        read_only      = 1'b1;
            IDX_CAL:      sel_o.cal      = 1'b1;
            5'h07:        exists         = 1'b0;
            IDX_ADC:      sel_o.adc      = 1'b1;
            IDX_SAMPLE:   sel_o.sample   = 1'b1;
            IDX_CTRL1:    sel_o.ctrl1    = 1'b1;
            IDX_CTRL2:    sel_o.ctrl2    = 1'b1;
            5'h12, 5'h13, 5'h14, 5'h15:
                          exists         = 1'b0;
            IDX_STATUS: begin
                sel_o.status = 1'b1;
                read_only    = 1'b1;
            end
            IDX_WDOG:     sel_o.wdog     = 1'b1;
            default: ;
        endcase
        legal_o = exists && !(write_i && read_only);
    end

endmodule

// File: rtl/pmic_adc_table.sv
module pmic_adc_table
    import pmic_pkg::*;
(
    input  logic [CHW-1:0]  chan_i,
    output logic [RESW-1:0] result_o
);

    always_comb begin
        case (chan_i)
            4'd1:    result_o = 10'h3C2;
            4'd2:    result_o = 10'h0FC;
            4'd3:    result_o = 10'h165;
            4'd4:    result_o = 10'h07B;
            4'd5:    result_o = 10'h3FF;
            4'd6:    result_o = 10'h011;
            4'd7:    result_o = 10'h011;
            4'd8:    result_o = 10'h250;
            4'd10:   result_o = 10'h002;
            4'd11:   result_o = 10'h011;
            4'd12:   result_o = 10'h3D0;
            4'd13:   result_o = 10'h330;
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile
    import pmic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          variant_i,
    input  logic          acc_valid_i,
    input  logic          acc_write_i,
    input  logic [IW-1:0] acc_index_i,
    input  logic [DW-1:0] acc_wdata_i,
    input  logic          key_event_i,
    input  logic          key_pressed_i,
    output logic [DW-1:0] acc_rdata_o,
    output logic          acc_err_o,
    output logic          irq_o,
    output logic          shutdown_o
);

    state_t st_d, st_q;

    reg_sel_t        sel;
    logic            legal;
    logic [RESW-1:0] adc_result;
    logic [DW-1:0]   rd_val;
    logic [CHW-1:0]  new_chan;

    pmic_idx_decode u_decode (
        .index_i (acc_index_i),
        .write_i (acc_write_i),
        .sel_o   (sel),
        .legal_o (legal)
    );

    pmic_adc_table u_adc (
        .chan_i   (st_q.chan),
        .result_o (adc_result)
    );

    assign new_chan = acc_wdata_i[ADC_CH_LSB +: CHW];

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        if (sel.id) begin
            rd_val             = ID_BASE;
            rd_val[ID_VAR_BIT] = variant_i;
        end
        if (sel.irq_st)   rd_val = st_q.irq_st;
        if (sel.irq_mask) rd_val = st_q.irq_mask;
        if (sel.cal)      rd_val = st_q.cal;
        if (sel.adc)      rd_val = {{ADC_PAD{1'b0}}, st_q.chan, adc_result};
        if (sel.sample)   rd_val = DW'(st_q.sample);
        if (sel.ctrl1)    rd_val = st_q.ctrl1;
        if (sel.ctrl2)    rd_val = st_q.ctrl2;
        if (sel.status)   rd_val = st_q.status;
    end

    // Next-state computation
    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        if (acc_valid_i) begin
            if (!legal) begin
                st_d.err = 1'b1;
                if (!acc_write_i) begin
                    st_d.rdata = '0;
                end
            end else if (!acc_write_i) begin
                st_d.rdata = rd_val;
            end else begin
                if (sel.irq_st)   st_d.irq_st   = st_q.irq_st ^ acc_wdata_i;
                if (sel.irq_mask) st_d.irq_mask = acc_wdata_i;
                if (sel.cal)      st_d.cal      = acc_wdata_i;
                if (sel.ctrl1)    st_d.ctrl1    = acc_wdata_i;
                if (sel.ctrl2)    st_d.ctrl2    = acc_wdata_i;
                if (sel.adc) begin
                    st_d.chan                = new_chan;
                    st_d.irq_st[IRQ_ADC_BIT] = 1'b1;
                    st_d.sample[new_chan]    = 1'b1;
                end
                if (sel.sample) begin
                    st_d.sample = st_q.sample & ~acc_wdata_i[NCH-1:0];
                end
                if (sel.wdog && (acc_wdata_i == '0) && st_q.ctrl1[WD_EN_BIT]) begin
                    st_d.shutdown = 1'b1;
                end
            end
        end

        // Key event lands after any same-cycle status write
        if (key_event_i) begin
            st_d.irq_st[IRQ_KEY_BIT]  = 1'b1;
            st_d.status[ST_KEYUP_BIT] = !key_pressed_i;
        end

        st_d.irq = |(st_d.irq_st & ~st_d.irq_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.irq_mask <= RST_MASK;
            st_q.status   <= RST_STATUS;
            st_q.cal      <= RST_CAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rdata_o = st_q.rdata;
    assign acc_err_o   = st_q.err;
    assign irq_o       = st_q.irq;
    assign shutdown_o  = st_q.shutdown;

endmodule

// File: rtl/pmic_regfile_chk.sv
module pmic_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid_i,
    input logic        acc_write_i,
    input logic [4:0]  acc_index_i,
    input logic [15:0] acc_wdata_i,
    input logic        key_event_i,
    input logic        key_pressed_i,
    input logic        acc_err_o,
    input logic        irq_o,
    input logic        shutdown_o,
    input logic [15:0] irq_st,
    input logic [15:0] irq_mask,
    input logic [15:0] status_reg
);

    // R1: a full mask silences the line on the next cycle
    p_mask_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && acc_index_i == 5'h02 && acc_wdata_i == 16'hFFFF)
        |=> !irq_o);

    // R2: first cycle after reset shows reset values
    p_reset_vals_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_mask == 16'hFFFF && irq_st == 16'h0000 && !irq_o && !shutdown_o));

    // R4: ADC write raises conversion-done status bit
    p_adc_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && acc_index_i == 5'h08) |=> irq_st[8]);

    // R7: shutdown is sticky
    p_shutdown_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> shutdown_o);

    // R7: nonzero watchdog write never requests shutdown
    p_wdog_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && acc_index_i == 5'h17 && acc_wdata_i != 16'h0 && !shutdown_o)
        |=> !shutdown_o);

    // R9: key event sets status bit 0 and key-up status bit
    p_key_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_event_i |=> (irq_st[0] && status_reg[5] == !$past(key_pressed_i)));

    // R10: no error without an access
    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> !acc_err_o);

    // R10: write to an undefined index leaves the mask untouched
    p_undef_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && acc_index_i == 5'h07) |=> $stable(irq_mask));

endmodule

bind pmic_regfile pmic_regfile_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid_i   (acc_valid_i),
    .acc_write_i   (acc_write_i),
    .acc_index_i   (acc_index_i),
    .acc_wdata_i   (acc_wdata_i),
    .key_event_i   (key_event_i),
    .key_pressed_i (key_pressed_i),
    .acc_err_o     (acc_err_o),
    .irq_o         (irq_o),
    .shutdown_o    (shutdown_o),
    .irq_st        (st_q.irq_st),
    .irq_mask      (st_q.irq_mask),
    .status_reg    (st_q.status)
);

// File: tb/pmic_regfile_test.sv
module pmic_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_i = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic        acc_write_i = 1'b0;
    logic [4:0]  acc_index_i = '0;
    logic [15:0] acc_wdata_i = '0;
    logic        key_event_i = 1'b0;
    logic        key_pressed_i = 1'b0;
    logic [15:0] acc_rdata_o;
    logic        acc_err_o;
    logic        irq_o;
    logic        shutdown_o;

    always #10 clk = ~clk;

    pmic_regfile uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .variant_i     (variant_i),
        .acc_valid_i   (acc_valid_i),
        .acc_write_i   (acc_write_i),
        .acc_index_i   (acc_index_i),
        .acc_wdata_i   (acc_wdata_i),
        .key_event_i   (key_event_i),
        .key_pressed_i (key_pressed_i),
        .acc_rdata_o   (acc_rdata_o),
        .acc_err_o     (acc_err_o),
        .irq_o         (irq_o),
        .shutdown_o    (shutdown_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    logic [15:0] m_ist, m_mask, m_cal, m_sample, m_c1, m_c2, m_stat;
    int          m_ch;
    logic [15:0] m_rd;
    logic        m_err, m_irq, m_sd;
    string       prev_tag = "R2";

    function automatic logic [15:0] preset(int ch);
        case (ch)
            1: return 16'h3C2;  2: return 16'h0FC;  3: return 16'h165;
            4: return 16'd123;  5: return 16'd1023; 6: return 16'h011;
            7: return 16'h011;  8: return 16'h250;  10: return 16'd2;
            11: return 16'h011; 12: return 16'h3D0; 13: return 16'h330;
            default: return 16'h0;
        endcase
    endfunction

    function automatic bit is_bad(int idx, bit w);
        if (idx == 7 || (idx >= 'h12 && idx <= 'h15)) return 1;
        if (w && (idx == 0 || idx == 4 || idx == 'h16)) return 1;
        return 0;
    endfunction

    function automatic logic [15:0] model_read(int idx, logic strap);
        case (idx)
            'h00: return strap ? 16'h0295 : 16'h0215;
            'h01: return m_ist;
            'h02: return m_mask;
            'h06: return m_cal;
            'h08: return 16'((m_ch << 10) | preset(m_ch));
            'h09: return m_sample;
            'h0D: return m_c1;
            'h0E: return m_c2;
            'h16: return m_stat;
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_ist = 16'h0; m_mask = 16'hFFFF; m_cal = 16'h0001; m_sample = 16'h0;
        m_c1 = 16'h0; m_c2 = 16'h0; m_stat = 16'h0020; m_ch = 0;
        m_rd = 16'h0; m_err = 0; m_irq = 0; m_sd = 0;
    endtask

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(prev_tag, "rdata", acc_rdata_o, m_rd);
        check("R10", "err", 16'(acc_err_o), 16'(m_err));
        check("R1", "irq", 16'(irq_o), 16'(m_irq));
        check("R7", "shutdown", 16'(shutdown_o), 16'(m_sd));
    endtask

    // Called at a falling edge: compare, drive, advance model, wait a cycle
    task automatic step(bit v, bit w, int idx, logic [15:0] wd, bit kev, bit kpr, string tag);
        compare_all();
        acc_valid_i   = v;
        acc_write_i   = w;
        acc_index_i   = 5'(idx);
        acc_wdata_i   = wd;
        key_event_i   = kev;
        key_pressed_i = kpr;
        m_err = 0;
        if (v) begin
            if (is_bad(idx, w)) begin
                m_err = 1;
                if (!w) m_rd = 16'h0;
            end else if (!w) begin
                m_rd = model_read(idx, variant_i);
            end else begin
                case (idx)
                    'h01: m_ist = m_ist ^ wd;
                    'h02: m_mask = wd;
                    'h06: m_cal = wd;
                    'h0D: m_c1 = wd;
                    'h0E: m_c2 = wd;
                    'h08: begin
                        m_ch = int'(wd[13:10]);
                        m_ist[8] = 1'b1;
                        m_sample[m_ch] = 1'b1;
                    end
                    'h09: m_sample = m_sample & ~wd;
                    'h17: if (wd == 16'h0 && m_c1[1]) m_sd = 1;
                    default: ;
                endcase
            end
        end
        if (kev) begin
            m_ist[0] = 1'b1;
            m_stat[5] = !kpr;
        end
        m_irq = |(m_ist & ~m_mask);
        if (v && !w) prev_tag = tag;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(int idx, string tag);
        step(1, 0, idx, 16'h0, 0, 0, tag);
    endtask

    task automatic wr(int idx, logic [15:0] d, string tag);
        step(1, 1, idx, d, 0, 0, tag);
    endtask

    task automatic idle();
        step(0, 0, 0, 16'h0, 0, 0, prev_tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset values
        rd('h02, "R2"); rd('h01, "R2"); rd('h16, "R2"); rd('h06, "R2");
        rd('h0D, "R2"); rd('h0E, "R2"); rd('h09, "R2");

        // R8: identification word with both strap values
        rd('h00, "R8");
        variant_i = 1'b1;
        rd('h00, "R8");
        variant_i = 1'b0;
        rd('h00, "R8");

        // R3: XOR toggling while fully masked
        wr('h01, 16'h0005, "R3"); rd('h01, "R3");
        wr('h01, 16'h0004, "R3"); rd('h01, "R3");

        // R1: mask opens and closes the line
        wr('h02, 16'hFFFE, "R1"); idle();
        wr('h02, 16'hFFFF, "R1"); idle();
        wr('h02, 16'h0000, "R1");
        wr('h01, 16'h0001, "R1"); idle();

        // R4 and R5: conversion trigger, readback on every channel
        wr('h08, 16'(5 << 10), "R4");
        rd('h01, "R4"); rd('h09, "R4");
        rd('h08, "R5");
        for (int ch = 0; ch < 16; ch++) begin
            wr('h08, 16'(ch << 10) | 16'h03FF, "R4");
            rd('h08, "R5");
        end
        rd('h09, "R4");

        // R6: sample flags cleared by a mask
        wr('h09, 16'h00F0, "R6"); rd('h09, "R6");
        wr('h09, 16'hFFFF, "R6"); rd('h09, "R6");

        // R9: key events, including event on top of a clearing write
        wr('h01, 16'hFFFF & m_ist, "R9"); rd('h01, "R9");
        step(0, 0, 0, 16'h0, 1, 1, "R9"); rd('h16, "R9"); rd('h01, "R9");
        step(0, 0, 0, 16'h0, 1, 0, "R9"); rd('h16, "R9");
        step(1, 1, 'h01, 16'h0001, 1, 1, "R9"); rd('h01, "R9"); rd('h16, "R9");

        // R10: illegal accesses change nothing
        rd('h07, "R10"); rd('h12, "R10"); rd('h15, "R10");
        wr('h07, 16'h1234, "R10"); wr('h13, 16'hFFFF, "R10");
        wr('h16, 16'h0000, "R10"); rd('h16, "R10");
        wr('h00, 16'hFFFF, "R10"); rd('h00, "R10");
        wr('h04, 16'hAAAA, "R10"); rd('h04, "R10");
        rd('h02, "R10"); rd('h01, "R10");

        // R11: stored and placeholder indices
        wr('h06, 16'h1234, "R11"); rd('h06, "R11");
        wr('h0E, 16'hBEEF, "R11"); rd('h0E, "R11");
        wr('h03, 16'hFFFF, "R11"); rd('h03, "R11");
        wr('h0B, 16'hFFFF, "R11"); rd('h0B, "R11");
        wr('h1F, 16'hFFFF, "R11"); rd('h1F, "R11");
        idle(); idle();

        // R7: watchdog gating
        wr('h17, 16'h0000, "R7"); idle();
        wr('h0D, 16'h0002, "R7");
        wr('h17, 16'h0005, "R7"); idle();
        rd('h17, "R11");
        wr('h17, 16'h0000, "R7"); idle(); idle();

        // Mixed traffic, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 7);
            if (r == 0) variant_i = $urandom_range(0, 1);
            step(r != 1, $urandom_range(0, 1), $urandom_range(0, 31),
                 16'($urandom), ($urandom_range(0, 7) == 0), $urandom_range(0, 1), "R11");
        end
        idle();
        compare_all();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule